// File: doc/BRIEF.md
# Predicate Mask Redirection Table

This block turns a register number into the predicate mask that governs the elements of an operation on that register. Configuration software fills a small store of compact key-value entries. Each entry names a register to be predicated and whether that register is an integer or a floating-point register. It also names the integer register that holds the mask, and it carries a complement flag and a zeroing flag. From this store the block keeps two expanded lookup tables with one slot for each register, one table for integer registers and one for floating-point registers.

The issue logic presents a register-class flag and a register number on the lookup port. The block selects the slot, drives the read address of the integer register file with the mask register that the slot names, and returns the mask. The mask is complemented when the slot asks for it. A register without a mapping gets an all-ones mask, so every element of an unmapped register stays active. The zeroing flag is passed out with the mask. The consumer uses it to choose between writing zeros to disabled elements and skipping them.

Every configuration write causes a full rebuild of both tables. The rebuild clears all slots first and then applies the entries in ascending index order. The lookup path is combinational from the registered tables and the register-file read data.

Top module: `pred_map_top`

## Requirements
- R1: After reset, and before any configuration write, every lookup returns an all-ones mask with `lk_hit` and `lk_zero` low.
- R2: An active entry of integer class with key K and mask register M makes an integer lookup of K drive `rf_addr` = M and return `rf_data` unchanged on `lk_mask`, with `lk_hit` high.
- R3: The class bit selects the table. An entry of floating-point class affects only floating-point lookups, and its mask is still read from the integer register file through `rf_addr`.
- R4: When the complement flag of the matching entry is set, `lk_mask` is the bitwise complement of `rf_data`.
- R5: `lk_zero` equals the zeroing flag of the matching entry, and it is low whenever `lk_hit` is low.
- R6: A lookup of a register whose slot is not mapped returns all ones on `lk_mask`, with `lk_hit` and `lk_zero` low.
- R7: When several active entries carry the same class and key, the entry with the highest index decides the slot. This holds whatever order the writes came in.
- R8: Each write rebuilds both tables from a cleared state. Rewriting an entry with another key, or with the active bit low, removes its old mapping. A lower-index entry with the same key then becomes visible again.
- R9: A write sampled at rising edge E is not visible to lookups between E and E+1. It is visible from rising edge E+1 onwards.
- R10: The write word `cfg_wdata` packs one entry as follows. Bit 13 is active and bit 12 is the class (0 integer, 1 floating point). Bits 11:7 hold the key, bits 6:2 the mask register, bit 1 the complement flag and bit 0 the zeroing flag. `cfg_idx` selects the entry to write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one store entry |
| cfg_idx | input | 4 | Index of the entry being written |
| cfg_wdata | input | 14 | Packed entry (layout in R10) |
| lk_is_fp | input | 1 | Lookup register class: 1 selects the floating-point table |
| lk_reg | input | 5 | Register number being looked up |
| rf_addr | output | 5 | Integer register file read address (mask register) |
| rf_data | input | 32 | Integer register file read data |
| lk_mask | output | 32 | Effective predicate mask |
| lk_zero | output | 1 | Zeroing requested for disabled elements |
| lk_hit | output | 1 | The looked-up slot is mapped |

## Verification
A corrupted table slot does not stay hidden. The next lookup of that register shows a wrong `rf_addr`, a mask that is neither the read data nor its complement, or a wrong hit or zeroing flag, all in the same cycle as the lookup. A stale or misordered rebuild shows up at the edge after a write. Either an old mapping survives, or a lower-index duplicate overrides a higher one. This is why each scenario writes, waits exactly to the visibility edge, and probes both tables at once, including slots that must be left untouched.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int REG_AW   = 5;
  localparam int NUM_REGS = 1 << REG_AW;

  typedef struct packed {
    logic              active;
    logic              is_fp;
    logic [REG_AW-1:0] key;
    logic [REG_AW-1:0] mreg;
    logic              inv;
    logic              zero;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  typedef struct packed {
    logic              en;
    logic              zero;
    logic              inv;
    logic [REG_AW-1:0] mreg;
  } slot_t;
endpackage

// File: rtl/pm_csr_store.sv
module pm_csr_store
  import pm_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IW = $clog2(NUM_ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IW-1:0]              idx,
  input  logic [ENTRY_W-1:0]         wdata,
  output entry_t [NUM_ENTRIES-1:0]   ents,
  output logic                       rebuild
);
  entry_t [NUM_ENTRIES-1:0] ent_q, ent_d;
  logic                     rebuild_q, rebuild_d;

  always_comb begin
    ent_d     = ent_q;
    rebuild_d = we;
    if (we && (int'(idx) < NUM_ENTRIES)) ent_d[idx] = entry_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q     <= '0;
      rebuild_q <= 1'b0;
    end else begin
      ent_q     <= ent_d;
      rebuild_q <= rebuild_d;
    end
  end

  assign ents    = ent_q;
  assign rebuild = rebuild_q;
endmodule

// File: rtl/pm_expand.sv
module pm_expand
  import pm_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  entry_t [NUM_ENTRIES-1:0]       ents,
  output slot_t  [1:0][NUM_REGS-1:0]     tbl
);
  for (genvar t = 0; t < 2; t++) begin : g_cls
    for (genvar s = 0; s < NUM_REGS; s++) begin : g_slot
      always_comb begin
        tbl[t][s] = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (ents[e].active && (ents[e].is_fp == 1'(t)) &&
              (ents[e].key == REG_AW'(s))) begin
            tbl[t][s].en   = 1'b1;
            tbl[t][s].zero = ents[e].zero;
            tbl[t][s].inv  = ents[e].inv;
            tbl[t][s].mreg = ents[e].mreg;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pm_table.sv
module pm_table
  import pm_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  slot_t [1:0][NUM_REGS-1:0]  tbl_in,
  output slot_t [1:0][NUM_REGS-1:0]  tbl_out
);
  slot_t [1:0][NUM_REGS-1:0] tbl_q, tbl_d;

  always_comb begin
    tbl_d = tbl_q;
    if (load) tbl_d = tbl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbl_q <= '0;
    else        tbl_q <= tbl_d;
  end

  assign tbl_out = tbl_q;
endmodule

// File: rtl/pm_lookup.sv
module pm_lookup
  import pm_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  slot_t [1:0][NUM_REGS-1:0] tbl,
  input  logic                      is_fp,
  input  logic [REG_AW-1:0]         rnum,
  output logic [REG_AW-1:0]         rf_addr,
  input  logic [XLEN-1:0]           rf_data,
  output logic [XLEN-1:0]           mask,
  output logic                      zero,
  output logic                      hit
);
  slot_t sel;

  always_comb begin
    sel     = tbl[is_fp][rnum];
    rf_addr = sel.mreg;
    hit     = sel.en;
    zero    = sel.en & sel.zero;
    if (!sel.en)     mask = '1;
    else if (sel.inv) mask = ~rf_data;
    else             mask = rf_data;
  end
endmodule

// File: rtl/pred_map_top.sv
module pred_map_top
  import pm_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  localparam int IW         = $clog2(NUM_ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IW-1:0]       cfg_idx,
  input  logic [ENTRY_W-1:0]  cfg_wdata,
  input  logic                lk_is_fp,
  input  logic [REG_AW-1:0]   lk_reg,
  output logic [REG_AW-1:0]   rf_addr,
  input  logic [XLEN-1:0]     rf_data,
  output logic [XLEN-1:0]     lk_mask,
  output logic                lk_zero,
  output logic                lk_hit
);
  entry_t [NUM_ENTRIES-1:0]  ents;
  logic                      rebuild;
  slot_t [1:0][NUM_REGS-1:0] tbl_new, tbl_cur;

  pm_csr_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
    .wdata(cfg_wdata), .ents(ents), .rebuild(rebuild)
  );

  pm_expand #(.NUM_ENTRIES(NUM_ENTRIES)) u_expand (
    .ents(ents), .tbl(tbl_new)
  );

  pm_table u_table (
    .clk(clk), .rst_n(rst_n), .load(rebuild),
    .tbl_in(tbl_new), .tbl_out(tbl_cur)
  );

  pm_lookup #(.XLEN(XLEN)) u_lookup (
    .tbl(tbl_cur), .is_fp(lk_is_fp), .rnum(lk_reg),
    .rf_addr(rf_addr), .rf_data(rf_data),
    .mask(lk_mask), .zero(lk_zero), .hit(lk_hit)
  );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [XLEN-1:0] rf_data,
  input logic [XLEN-1:0] lk_mask,
  input logic            lk_zero,
  input logic            lk_hit
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_q <= 1'b0;
    else if (cfg_we) seen_q <= 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (!lk_hit && (lk_mask == '1)));

  assert_mask_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((lk_mask == rf_data) || (lk_mask == ~rf_data)));

  assert_zero_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_zero |-> lk_hit);

  assert_unmapped_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> ((lk_mask == '1) && !lk_zero));
endmodule

bind pred_map_top pm_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .rf_data(rf_data),
  .lk_mask(lk_mask), .lk_zero(lk_zero), .lk_hit(lk_hit)
);

// File: tb/pred_map_top_tb.sv
module pred_map_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [13:0] cfg_wdata;
  logic        lk_is_fp;
  logic [4:0]  lk_reg;
  logic [4:0]  rf_addr;
  logic [31:0] rf_data;
  logic [31:0] lk_mask;
  logic        lk_zero;
  logic        lk_hit;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] rfval(input int i);
    return (32'h0103_0507 * (i + 1)) ^ 32'hC3A5_0000;
  endfunction

  assign rf_data = rfval(int'(rf_addr));

  pred_map_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .lk_is_fp(lk_is_fp), .lk_reg(lk_reg),
    .rf_addr(rf_addr), .rf_data(rf_data), .lk_mask(lk_mask),
    .lk_zero(lk_zero), .lk_hit(lk_hit)
  );

  // R10 layout: active, class, key, mask register, complement, zeroing
  task automatic put(input int idx, input bit act, input bit fp, input int key,
                     input int mr, input bit inv, input bit zr);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_idx   = 4'(idx);
    cfg_wdata = {act, fp, 5'(key), 5'(mr), inv, zr};
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic probe(input string req, input bit fp, input int r,
                       input logic [31:0] em, input bit ez, input bit eh);
    lk_is_fp = fp;
    lk_reg   = 5'(r);
    #1;
    n_chk++;
    if (lk_mask !== em || lk_zero !== ez || lk_hit !== eh) begin
      n_fail++;
      $display("FAIL %s fp=%0d reg=%0d: mask=%h zero=%b hit=%b, expected mask=%h zero=%b hit=%b",
               req, fp, r, lk_mask, lk_zero, lk_hit, em, ez, eh);
    end
  endtask

  task automatic probe_addr(input string req, input bit fp, input int r, input int ea);
    lk_is_fp = fp;
    lk_reg   = 5'(r);
    #1;
    n_chk++;
    if (rf_addr !== 5'(ea)) begin
      n_fail++;
      $display("FAIL %s rf_addr=%0d expected %0d", req, rf_addr, ea);
    end
  endtask

  task automatic t_reset();
    probe("R1", 0, 0, '1, 0, 0);
    probe("R1", 1, 31, '1, 0, 0);
    probe("R1", 0, 17, '1, 0, 0);
  endtask

  task automatic t_int_map();
    put(0, 1, 0, 3, 7, 0, 0); settle();
    probe("R2", 0, 3, rfval(7), 0, 1);
    probe_addr("R2", 0, 3, 7);
    probe("R3", 1, 3, '1, 0, 0);
  endtask

  task automatic t_fp_invert();
    put(1, 1, 1, 3, 9, 1, 0); settle();
    probe("R3", 1, 3, ~rfval(9), 0, 1);
    probe_addr("R3", 1, 3, 9);
    probe("R4", 0, 3, rfval(7), 0, 1);
  endtask

  task automatic t_zero();
    put(2, 1, 0, 10, 1, 0, 1); settle();
    probe("R5", 0, 10, rfval(1), 1, 1);
    probe("R5", 0, 3, rfval(7), 0, 1);
  endtask

  task automatic t_timing();
    put(3, 1, 0, 12, 2, 0, 0);
    probe("R9", 0, 12, '1, 0, 0);
    settle();
    probe("R9", 0, 12, rfval(2), 0, 1);
  endtask

  task automatic t_dup();
    put(5, 1, 0, 20, 4, 0, 0);
    put(9, 1, 0, 20, 6, 0, 0); settle();
    probe("R7", 0, 20, rfval(6), 0, 1);
    put(4, 1, 0, 20, 8, 1, 1); settle();
    probe("R7", 0, 20, rfval(6), 0, 1);
  endtask

  task automatic t_rebuild();
    put(9, 0, 0, 20, 6, 0, 0); settle();
    probe("R8", 0, 20, rfval(4), 0, 1);
    put(0, 1, 0, 4, 11, 0, 0); settle();
    probe("R8", 0, 3, '1, 0, 0);
    probe("R8", 0, 4, rfval(11), 0, 1);
    probe("R8", 1, 3, ~rfval(9), 0, 1);
  endtask

  task automatic t_unmapped();
    probe("R6", 0, 31, '1, 0, 0);
    probe("R6", 1, 20, '1, 0, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    lk_is_fp = 1'b0; lk_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_int_map();
    t_fp_invert();
    t_zero();
    t_timing();
    t_dup();
    t_rebuild();
    t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule